// File: doc/BRIEF.md
# Two-Phase Toggle Handshake Bridge

This block carries one data word at a time from a sender clock domain to an unrelated receiver clock domain. It uses a non-return-to-zero handshake. The sender announces a word by inverting its request level. The receiver answers by copying that level onto its acknowledge wire. Both matched level pairs, low/low and high/high, count as idle. A transfer therefore costs one transition on each wire instead of the two that a return-to-zero scheme needs.

Each domain brings the other side's handshake wire in through a two-flop synchronizer. It detects a new event by comparing the synchronized level with its value one cycle earlier. The sender holds the word steady from the moment its request changes until the matching acknowledge has been seen. So the receiver can capture the bus on the cycle it detects the change, and it emits one valid strobe per word. An optional watchdog counter in the sender domain raises a sticky error flag when an acknowledge takes too long.

Top module: `xdom_toggle_bridge`

## Requirements
- R1: After reset, `s_ready` is 1, `s_done` is 0, `s_timeout` is 0, `r_valid` is 0 and `r_data` is all zeros. Both handshake levels start low.
- R2: A word on `s_data` is taken only when `s_start` is 1 at a rising `s_clk` edge while `s_ready` is 1. A start while `s_ready` is 0 is ignored: that word is never delivered and the transfer in flight is not disturbed.
- R3: Every accepted word appears on `r_data` with `r_valid` high for exactly one `r_clk` cycle. Words arrive in acceptance order, and there is exactly one strobe per accepted word.
- R4: `s_ready` is 0 from the cycle after acceptance until the synchronized acknowledge level equals the request level. `s_done` is high for exactly one `s_clk` cycle per completed transfer.
- R5: Each accepted start inverts the request level, whichever level it holds. Transfers that begin from the low idle pair and from the high idle pair complete identically, so back-to-back transfers of any count all deliver.
- R6: The word driven toward the receiver does not change while the sender is busy.
- R7: With `TIMEOUT_CYC` > 0, `s_timeout` becomes 1 after `TIMEOUT_CYC` busy sender cycles without a matching acknowledge. The sender stays busy until the levels match. The flag stays set after completion and clears on the next accepted start. With `TIMEOUT_CYC` = 0, no counter is built and the flag stays 0.
- R8: `r_data` keeps the last delivered word between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_clk | input | 1 | Sender domain clock |
| s_rst_n | input | 1 | Sender domain asynchronous active-low reset |
| s_start | input | 1 | Request to send the word on s_data |
| s_data | input | W | Word to send |
| s_ready | output | 1 | Sender idle; a start will be accepted |
| s_done | output | 1 | One-cycle pulse when a transfer is acknowledged |
| s_timeout | output | 1 | Sticky acknowledge-timeout flag |
| r_clk | input | 1 | Receiver domain clock |
| r_rst_n | input | 1 | Receiver domain asynchronous active-low reset |
| r_data | output | W | Last word received |
| r_valid | output | 1 | One-cycle strobe for a new word on r_data |

## Verification
The bench builds the bridge with a 16-bit word and `TIMEOUT_CYC` = 60. The sender runs at 200 MHz and the receiver clock has an unrelated 7 ns period. A limit of 60 cycles puts the timeout within a short run. The bench provokes it by holding only the receiver domain in reset, which freezes the acknowledge level. Releasing that reset then shows the late completion and the sticky flag. The bench also runs an odd and an even number of back-to-back words, so transfers start from both idle level pairs.

// File: rtl/xtb_pkg.sv
package xtb_pkg;
  // Width of a counter that must reach the value n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/xtb_sync2.sv
module xtb_sync2 #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      hold_q <= RST_VAL;
    end else begin
      meta_q <= d_async;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/xtb_send.sv
module xtb_send
  import xtb_pkg::*;
#(
  parameter int W           = 16,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] data,
  input  logic         ack_async,
  output logic         req,
  output logic [W-1:0] tx_data,
  output logic         ready,
  output logic         done,
  output logic         timeout
);
  logic         req_q, req_d;
  logic [W-1:0] data_q, data_d;
  logic         ack_s, ack_prev_q;
  logic         busy, accept;

  xtb_sync2 #(.RST_VAL(1'b0)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ack_async), .q(ack_s)
  );

  always_comb begin
    busy   = req_q ^ ack_s;
    accept = start & ~busy;
    req_d  = accept ? ~req_q : req_q;
    data_d = accept ? data : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q      <= 1'b0;
      data_q     <= '0;
      ack_prev_q <= 1'b0;
    end else begin
      req_q      <= req_d;
      ack_prev_q <= ack_s;
      if (accept) data_q <= data_d;
    end
  end

  assign req     = req_q;
  assign tx_data = data_q;
  assign ready   = ~busy;
  assign done    = ack_s ^ ack_prev_q;

  generate
    if (TIMEOUT_CYC > 0) begin : g_tmo
      localparam int CW = cnt_width(TIMEOUT_CYC);
      localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);
      localparam logic [CW-1:0] TOP  = CW'(TIMEOUT_CYC);
      logic [CW-1:0] cnt_q, cnt_d;
      logic          err_q, err_d;

      always_comb begin
        cnt_d = cnt_q;
        if (!busy)            cnt_d = '0;
        else if (cnt_q != TOP) cnt_d = cnt_q + 1'b1;
        err_d = err_q;
        if (accept)                       err_d = 1'b0;
        else if (busy && (cnt_q == LAST)) err_d = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
          err_q <= 1'b0;
        end else begin
          cnt_q <= cnt_d;
          err_q <= err_d;
        end
      end

      assign timeout = err_q;

      AST_TMO_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(busy)); // R7
      AST_TMO_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP); // R7
    end else begin : g_no_tmo
      assign timeout = 1'b0;
    end
  endgenerate

  AST_REQ_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q != $past(req_q)) |-> ($past(ack_s) == $past(req_q))); // R5
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(data_q)); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready); // R4
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready); // R2
endmodule

// File: rtl/xtb_recv.sv
module xtb_recv #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_async,
  input  logic [W-1:0] data_async,
  output logic         ack,
  output logic [W-1:0] data,
  output logic         valid
);
  logic         req_s, req_prev_q;
  logic         strobe;
  logic         ack_q, ack_d;
  logic [W-1:0] data_q;
  logic         valid_q;

  xtb_sync2 #(.RST_VAL(1'b0)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d_async(req_async), .q(req_s)
  );

  always_comb begin
    strobe = req_s ^ req_prev_q;
    ack_d  = strobe ? req_s : ack_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev_q <= 1'b0;
      ack_q      <= 1'b0;
      data_q     <= '0;
      valid_q    <= 1'b0;
    end else begin
      req_prev_q <= req_s;
      ack_q      <= ack_d;
      valid_q    <= strobe;
      if (strobe) data_q <= data_async;
    end
  end

  assign ack   = ack_q;
  assign data  = data_q;
  assign valid = valid_q;

  AST_ACK_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (ack_q == $past(req_s))); // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R3
  AST_DATA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(data_q)); // R8
endmodule

// File: rtl/xdom_toggle_bridge.sv
module xdom_toggle_bridge #(
  parameter int W           = 16,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic         s_clk,
  input  logic         s_rst_n,
  input  logic         s_start,
  input  logic [W-1:0] s_data,
  output logic         s_ready,
  output logic         s_done,
  output logic         s_timeout,
  input  logic         r_clk,
  input  logic         r_rst_n,
  output logic [W-1:0] r_data,
  output logic         r_valid
);
  logic         hs_req;
  logic         hs_ack;
  logic [W-1:0] hs_bus;

  xtb_send #(.W(W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_send (
    .clk(s_clk), .rst_n(s_rst_n), .start(s_start), .data(s_data),
    .ack_async(hs_ack), .req(hs_req), .tx_data(hs_bus),
    .ready(s_ready), .done(s_done), .timeout(s_timeout)
  );

  xtb_recv #(.W(W)) u_recv (
    .clk(r_clk), .rst_n(r_rst_n), .req_async(hs_req), .data_async(hs_bus),
    .ack(hs_ack), .data(r_data), .valid(r_valid)
  );
endmodule

// File: tb/sim_xdom_toggle_bridge.sv
module sim_xdom_toggle_bridge;
  localparam int W   = 16;
  localparam int TMO = 60;

  logic         s_clk = 1'b0, r_clk = 1'b0;
  logic         s_rst_n = 1'b0, r_rst_n = 1'b0;
  logic         s_start = 1'b0;
  logic [W-1:0] s_data = '0;
  logic         s_ready, s_done, s_timeout, r_valid;
  logic [W-1:0] r_data;

  int checks = 0, errors = 0;
  int accepted = 0, delivered = 0, dones = 0;
  logic [W-1:0] expq[$];
  logic [W-1:0] last_word = '0;
  logic         prev_valid = 1'b0;
  bit           finished = 1'b0;

  always #2.5 s_clk = ~s_clk;
  always #3.5 r_clk = ~r_clk;

  xdom_toggle_bridge #(.W(W), .TIMEOUT_CYC(TMO)) u0 (
    .s_clk(s_clk), .s_rst_n(s_rst_n), .s_start(s_start), .s_data(s_data),
    .s_ready(s_ready), .s_done(s_done), .s_timeout(s_timeout),
    .r_clk(r_clk), .r_rst_n(r_rst_n), .r_data(r_data), .r_valid(r_valid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: offers one word; pushes expectation when accepted
  task automatic send(input logic [W-1:0] w, output bit acc);
    @(negedge s_clk);
    s_data  = w;
    s_start = 1'b1;
    acc     = s_ready;
    if (acc) begin
      expq.push_back(w);
      accepted++;
      last_word = w;
    end
    @(negedge s_clk);
    s_start = 1'b0;
    if (acc) check(s_ready == 1'b0, "R4 busy after accept", s_ready, 0);
  endtask

  task automatic wait_idle();
    while (!s_ready) @(negedge s_clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && expq.size() != 0; i++) @(negedge r_clk);
  endtask

  // monitor / scoreboard
  always @(negedge r_clk) begin
    if (r_rst_n) begin
      if (r_valid) begin
        delivered++;
        if (prev_valid) check(1'b0, "R3 strobe longer than one cycle", 1, 0);
        if (expq.size() == 0) check(1'b0, "R3 unexpected word", r_data, 0);
        else begin
          logic [W-1:0] e;
          e = expq.pop_front();
          check(r_data == e, "R3 word order/value", r_data, e);
        end
      end
      prev_valid = r_valid;
    end else prev_valid = 1'b0;
  end

  always @(negedge s_clk) if (s_rst_n && s_done) dones++;

  initial begin
    repeat (100000) @(posedge s_clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit acc;
    repeat (4) @(negedge s_clk);
    s_rst_n = 1'b1;
    @(negedge r_clk); r_rst_n = 1'b1;
    repeat (3) @(negedge s_clk);
    // R1
    check(s_ready == 1'b1, "R1 ready", s_ready, 1);
    check(s_timeout == 1'b0, "R1 timeout", s_timeout, 0);
    check(s_done == 1'b0, "R1 done", s_done, 0);
    check(r_valid == 1'b0, "R1 valid", r_valid, 0);
    check(r_data == '0, "R1 data", r_data, 0);

    // single transfer
    send(16'hA5C3, acc);
    check(acc == 1'b1, "R2 accept when ready", acc, 1);
    wait_idle(); drain();
    check(expq.size() == 0, "R3 first word delivered", expq.size(), 0);

    // start while busy is ignored
    send(16'h1234, acc);
    send(16'hDEAD, acc);
    check(acc == 1'b0, "R2 start ignored while busy", acc, 0);
    wait_idle(); drain();
    check(r_data == 16'h1234, "R2 busy word not delivered", r_data, 16'h1234);

    // back-to-back from alternating idle levels
    for (int i = 0; i < 9; i++) begin
      wait_idle();
      send(16'h0F00 + 16'(i * 37), acc);
      check(acc == 1'b1, "R5 back-to-back accept", acc, 1);
    end
    wait_idle(); drain();
    check(expq.size() == 0, "R5 all burst words delivered", expq.size(), 0);

    // R8 data held between strobes
    repeat (20) @(negedge r_clk);
    check(r_data == last_word, "R8 data held", r_data, last_word);

    if (accepted % 2 != 0) begin
      send(16'h7777, acc);
      wait_idle(); drain();
    end

    // timeout: freeze acknowledge by holding receiver in reset
    @(negedge r_clk); r_rst_n = 1'b0;
    send(16'hBEEF, acc);
    check(acc == 1'b1, "R7 timeout word accepted", acc, 1);
    repeat (TMO - 4) @(negedge s_clk);
    check(s_timeout == 1'b0, "R7 no flag before limit", s_timeout, 0);
    repeat (10) @(negedge s_clk);
    check(s_timeout == 1'b1, "R7 flag after limit", s_timeout, 1);
    check(s_ready == 1'b0, "R7 still busy after timeout", s_ready, 0);
    @(negedge r_clk); r_rst_n = 1'b1;
    wait_idle(); drain();
    check(expq.size() == 0, "R7 late word delivered", expq.size(), 0);
    check(s_timeout == 1'b1, "R7 flag sticky", s_timeout, 1);
    send(16'h4242, acc);
    check(s_timeout == 1'b0, "R7 flag cleared by start", s_timeout, 0);
    wait_idle(); drain();

    repeat (10) @(negedge s_clk);
    check(delivered == accepted, "R3 one strobe per word", delivered, accepted);
    check(dones == accepted, "R4 one done per transfer", dones, accepted);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule